// File: doc/BRIEF.md
# Core Idle-Level Controller

This block follows one processor core through its idle levels. The levels are active, halt, monitor-wait at level 1, level 2, level 3 and level 4. Decoded entry requests move the core from active into an idle level. These requests are a halt, a monitor-wait with a target level, or a read of one of the level registers. Wake sources bring the core back to active. Snoops are treated differently by level. In the two shallow levels and in level 2, the core steps out briefly to service a snoop and then returns. In levels 3 and 4 the core stays asleep and snoops are not serviced.

Entry to levels 3 and 4 goes through a flush handshake. The block raises a flush request and waits for a done pulse before the deep level is reached. A wake that arrives while the flush is pending cancels the entry. The block drives a clock-stop enable for the deep levels. It also drives a deep-idle flag in level 4 that a package coordinator can combine across cores, and a stop-grant acknowledge in level 2 while the stop-clock input is high.

All pins are plain level-sensitive controls; the block has no data stream and no handshake at its boundary other than the flush and snoop pairs. Wake inputs are levels: a source holds its line until the core is active again.

Top module: `core_idle_ctl`

## Requirements
- R1: After reset the state code is 0 (active), the one-hot status has only bit 0 set, and clk_stop, flush_req, snoop_svc, deep_idle and stopgnt_ack are all low. The state codes are: active 0, halt 1, monitor-wait 2, level 2 3, level 3 4, level 4 5, snoop service 6, flushing 7. One-hot bit i is set exactly when the state code equals i.
- R2: Entry requests are taken only in active. The priority is halt_req over mwait_req over lvl_rd_req. mwait_lvl values 0, 1, 2 and 3 select monitor-wait, level 2, level 3 and level 4. lvl_rd_idx 2 selects level 2, 3 selects level 3, and 4 or 5 select level 4. Any other index does nothing, and requests in any other state are ignored.
- R3: Halt returns to active on SMI, INIT, NMI, INTR or an interrupt message. A monitor event alone leaves it in halt.
- R4: Monitor-wait and level 2 return to active on any wake source, the monitor event included.
- R5: In halt, monitor-wait or level 2, a snoop with no wake present moves the core to snoop service (snoop_svc high). On snoop_done the core returns to the level it came from. Wake inputs are not acted on during snoop service, and a wake seen together with a snoop takes priority.
- R6: A level 3 or level 4 request enters the flushing state, where flush_req is high. On flush_done the core moves to the requested deep level.
- R7: Any wake during flushing returns the core to active, even if flush_done arrives in the same cycle.
- R8: In levels 3 and 4 clk_stop is high, snoops cause no change, and any wake source returns the core to active.
- R9: deep_idle is high only in level 4.
- R10: stopgnt_ack is high only in level 2 while stpclk is high.
- R11: Reset low forces active at once, from any state, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req | input | 1 | Halt entry request |
| mwait_req | input | 1 | Monitor-wait entry request |
| mwait_lvl | input | 2 | Target level of the monitor-wait |
| lvl_rd_req | input | 1 | Level-register read strobe |
| lvl_rd_idx | input | LVL_IDX_W | Index of the level register read |
| snoop_req | input | 1 | Bus snoop or sibling cacheable access |
| snoop_done | input | 1 | Snoop service finished |
| flush_done | input | 1 | L1 flush finished |
| mon_evt | input | 1 | Monitor event |
| smi | input | 1 | System-management interrupt |
| init | input | 1 | INIT request |
| nmi | input | 1 | Non-maskable interrupt |
| intr | input | 1 | Maskable interrupt |
| int_msg | input | 1 | Interrupt message from the bus |
| stpclk | input | 1 | External stop-clock request |
| state | output | 3 | Current state code |
| state_oh | output | 8 | One-hot status, one bit per state code |
| clk_stop | output | 1 | Core clocks may be stopped |
| flush_req | output | 1 | Request for an L1 flush |
| snoop_svc | output | 1 | Core is servicing a snoop |
| deep_idle | output | 1 | Core is in level 4 |
| stopgnt_ack | output | 1 | Stop-grant acknowledge |

## Verification
The hardest case to reach is the flushing window. Here a wake, a flush completion and a snoop can arrive together, and only the wake may win. The stimulus holds flush_done low for several cycles. It then raises INIT alone, and in a later entry raises INIT in the same cycle as flush_done, to check that the entry is aborted. A snoop arriving inside a shallow level is also sent through the service sub-state from each of the three origins, to show that the return goes to the right level. A long weighted random phase then mixes all the inputs against the cycle model.

// File: rtl/idle_pkg.sv
package idle_pkg;
  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_HALT = 3'd1,
    ST_MWT  = 3'd2,
    ST_L2   = 3'd3,
    ST_L3   = 3'd4,
    ST_L4   = 3'd5,
    ST_SNP  = 3'd6,
    ST_FLS  = 3'd7
  } idle_st_e;

  typedef enum logic [2:0] {
    TG_NONE = 3'd0,
    TG_HALT = 3'd1,
    TG_MWT  = 3'd2,
    TG_L2   = 3'd3,
    TG_L3   = 3'd4,
    TG_L4   = 3'd5
  } idle_tgt_e;

  localparam int unsigned NUM_ST = 8;
  localparam int unsigned ST_W   = 3;
endpackage

// File: rtl/idle_req_decode.sv
module idle_req_decode
  import idle_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             halt_req,
  input  logic             mwait_req,
  input  logic [1:0]       mwait_lvl,
  input  logic             lvl_rd_req,
  input  logic [IDX_W-1:0] lvl_rd_idx,
  output idle_tgt_e        tgt
);
  idle_tgt_e mw_tgt;
  idle_tgt_e rd_tgt;

  always_comb begin
    unique case (mwait_lvl)
      2'd0:    mw_tgt = TG_MWT;
      2'd1:    mw_tgt = TG_L2;
      2'd2:    mw_tgt = TG_L3;
      default: mw_tgt = TG_L4;
    endcase
  end

  always_comb begin
    if (lvl_rd_idx == IDX_W'(2))
      rd_tgt = TG_L2;
    else if (lvl_rd_idx == IDX_W'(3))
      rd_tgt = TG_L3;
    else if (lvl_rd_idx == IDX_W'(4) || lvl_rd_idx == IDX_W'(5))
      rd_tgt = TG_L4;
    else
      rd_tgt = TG_NONE;
  end

  always_comb begin
    if (halt_req)        tgt = TG_HALT;
    else if (mwait_req)  tgt = mw_tgt;
    else if (lvl_rd_req) tgt = rd_tgt;
    else                 tgt = TG_NONE;
  end
endmodule

// File: rtl/idle_wake_merge.sv
module idle_wake_merge #(
  parameter int unsigned N_INT = 5
) (
  input  logic [N_INT-1:0] int_src,
  input  logic             mon_evt,
  output logic             int_wake,
  output logic             any_wake
);
  assign int_wake = |int_src;
  assign any_wake = int_wake | mon_evt;
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
  import idle_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  idle_tgt_e tgt,
  input  logic      int_wake,
  input  logic      any_wake,
  input  logic      snoop_req,
  input  logic      snoop_done,
  input  logic      flush_done,
  output idle_st_e  st
);
  idle_st_e st_q, st_d;
  idle_st_e ret_q, ret_d;
  logic     deep_q, deep_d;

  always_comb begin
    st_d   = st_q;
    ret_d  = ret_q;
    deep_d = deep_q;
    unique case (st_q)
      ST_ACT: begin
        unique case (tgt)
          TG_HALT: st_d = ST_HALT;
          TG_MWT:  st_d = ST_MWT;
          TG_L2:   st_d = ST_L2;
          TG_L3:   begin st_d = ST_FLS; deep_d = 1'b0; end
          TG_L4:   begin st_d = ST_FLS; deep_d = 1'b1; end
          default: st_d = ST_ACT;
        endcase
      end
      ST_HALT: begin
        if (int_wake) st_d = ST_ACT;
        else if (snoop_req) begin st_d = ST_SNP; ret_d = ST_HALT; end
      end
      ST_MWT, ST_L2: begin
        if (any_wake) st_d = ST_ACT;
        else if (snoop_req) begin st_d = ST_SNP; ret_d = st_q; end
      end
      ST_SNP: begin
        if (snoop_done) st_d = ret_q;
      end
      ST_FLS: begin
        if (any_wake) st_d = ST_ACT;
        else if (flush_done) st_d = deep_q ? ST_L4 : ST_L3;
      end
      ST_L3, ST_L4: begin
        if (any_wake) st_d = ST_ACT;
      end
      default: st_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ACT;
      ret_q  <= ST_HALT;
      deep_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ret_q  <= ret_d;
      deep_q <= deep_d;
    end
  end

  assign st = st_q;

  // R8
  deep_snoop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_L3 || st_q == ST_L4) && snoop_req && !any_wake) |=> (st_q == $past(st_q)));

  // R6
  deep_via_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_L3 || st_q == ST_L4) |-> ($past(st_q) == ST_FLS));

  // R7
  flush_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLS && any_wake) |=> (st_q == ST_ACT));

  // R3
  halt_mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && !int_wake && !snoop_req) |=> (st_q == ST_HALT));

  // R5
  snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SNP && snoop_done) |=> (st_q == ST_HALT || st_q == ST_MWT || st_q == ST_L2));
endmodule

// File: rtl/core_idle_ctl.sv
module core_idle_ctl
  import idle_pkg::*;
#(
  parameter int unsigned LVL_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_req,
  input  logic                 mwait_req,
  input  logic [1:0]           mwait_lvl,
  input  logic                 lvl_rd_req,
  input  logic [LVL_IDX_W-1:0] lvl_rd_idx,
  input  logic                 snoop_req,
  input  logic                 snoop_done,
  input  logic                 flush_done,
  input  logic                 mon_evt,
  input  logic                 smi,
  input  logic                 init,
  input  logic                 nmi,
  input  logic                 intr,
  input  logic                 int_msg,
  input  logic                 stpclk,
  output logic [2:0]           state,
  output logic [7:0]           state_oh,
  output logic                 clk_stop,
  output logic                 flush_req,
  output logic                 snoop_svc,
  output logic                 deep_idle,
  output logic                 stopgnt_ack
);
  localparam int unsigned N_INT = 5;

  idle_tgt_e  tgt;
  idle_st_e   st;
  logic       int_wake, any_wake;
  logic [N_INT-1:0] int_src;

  assign int_src = {smi, init, nmi, intr, int_msg};

  idle_req_decode #(.IDX_W(LVL_IDX_W)) u_dec (
    .halt_req   (halt_req),
    .mwait_req  (mwait_req),
    .mwait_lvl  (mwait_lvl),
    .lvl_rd_req (lvl_rd_req),
    .lvl_rd_idx (lvl_rd_idx),
    .tgt        (tgt)
  );

  idle_wake_merge #(.N_INT(N_INT)) u_wake (
    .int_src  (int_src),
    .mon_evt  (mon_evt),
    .int_wake (int_wake),
    .any_wake (any_wake)
  );

  idle_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tgt        (tgt),
    .int_wake   (int_wake),
    .any_wake   (any_wake),
    .snoop_req  (snoop_req),
    .snoop_done (snoop_done),
    .flush_done (flush_done),
    .st         (st)
  );

  assign state = st;

  for (genvar i = 0; i < NUM_ST; i++) begin : g_oh
    assign state_oh[i] = (st == idle_st_e'(i));
  end

  assign clk_stop    = (st == ST_L3) || (st == ST_L4);
  assign flush_req   = (st == ST_FLS);
  assign snoop_svc   = (st == ST_SNP);
  assign deep_idle   = (st == ST_L4);
  assign stopgnt_ack = (st == ST_L2) && stpclk;

  // R9
  deep_flag_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_idle && any_wake) |=> !deep_idle);

  // R5
  snoop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_L2 && snoop_req && !any_wake) |=> snoop_svc);

  // R10
  stopgnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopgnt_ack && !any_wake && !snoop_req && $stable(stpclk)) |=> stopgnt_ack || !stpclk);
endmodule

// File: tb/core_idle_ctl_tb.sv
`timescale 1ns/1ps
module core_idle_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, mwait_req = 0, lvl_rd_req = 0;
  logic [1:0] mwait_lvl = 0;
  logic [2:0] lvl_rd_idx = 0;
  logic snoop_req = 0, snoop_done = 0, flush_done = 0;
  logic mon_evt = 0, smi = 0, init = 0, nmi = 0, intr = 0, int_msg = 0, stpclk = 0;
  logic [2:0] state;
  logic [7:0] state_oh;
  logic clk_stop, flush_req, snoop_svc, deep_idle, stopgnt_ack;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  int m_st = 0, m_ret = 1, m_deep = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  core_idle_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .mwait_req(mwait_req),
    .mwait_lvl(mwait_lvl), .lvl_rd_req(lvl_rd_req), .lvl_rd_idx(lvl_rd_idx),
    .snoop_req(snoop_req), .snoop_done(snoop_done), .flush_done(flush_done),
    .mon_evt(mon_evt), .smi(smi), .init(init), .nmi(nmi), .intr(intr),
    .int_msg(int_msg), .stpclk(stpclk), .state(state), .state_oh(state_oh),
    .clk_stop(clk_stop), .flush_req(flush_req), .snoop_svc(snoop_svc),
    .deep_idle(deep_idle), .stopgnt_ack(stopgnt_ack)
  );

  // Behavioural reference: 0 act,1 halt,2 mwait,3 L2,4 L3,5 L4,6 snoop,7 flush
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ret = 1; m_deep = 0;
    end else begin
      bit iw, aw;
      int t;
      iw = smi | init | nmi | intr | int_msg;
      aw = iw | mon_evt;
      t = 0;
      if (halt_req) t = 1;
      else if (mwait_req) t = 2 + mwait_lvl;
      else if (lvl_rd_req) begin
        if (lvl_rd_idx == 2) t = 3;
        else if (lvl_rd_idx == 3) t = 4;
        else if (lvl_rd_idx == 4 || lvl_rd_idx == 5) t = 5;
      end
      case (m_st)
        0: if (t == 4 || t == 5) begin m_deep = (t == 5); m_st = 7; end
           else if (t != 0) m_st = t;
        1: if (iw) m_st = 0; else if (snoop_req) begin m_ret = 1; m_st = 6; end
        2, 3: if (aw) m_st = 0; else if (snoop_req) begin m_ret = m_st; m_st = 6; end
        6: if (snoop_done) m_st = m_ret;
        7: if (aw) m_st = 0; else if (flush_done) m_st = m_deep ? 5 : 4;
        default: if (aw) m_st = 0;
      endcase
    end
  end

  task automatic chk();
    logic [7:0] e_oh;
    logic e_cs, e_fr, e_sv, e_di, e_sg;
    e_oh = 8'(1) << m_st;
    e_cs = (m_st == 4 || m_st == 5);
    e_fr = (m_st == 7);
    e_sv = (m_st == 6);
    e_di = (m_st == 5);
    e_sg = (m_st == 3) && stpclk;
    checks++;
    if (state !== 3'(m_st) || state_oh !== e_oh || clk_stop !== e_cs ||
        flush_req !== e_fr || snoop_svc !== e_sv || deep_idle !== e_di || stopgnt_ack !== e_sg) begin
      fails++;
      $display("FAIL %s t=%0t: got st=%0d oh=%b cs%b fr%b sv%b di%b sg%b, exp st=%0d oh=%b cs%b fr%b sv%b di%b sg%b",
               cur_req, $time, state, state_oh, clk_stop, flush_req, snoop_svc, deep_idle, stopgnt_ack,
               m_st, e_oh, e_cs, e_fr, e_sv, e_di, e_sg);
    end
  endtask

  task automatic clr();
    halt_req = 0; mwait_req = 0; lvl_rd_req = 0; mwait_lvl = 0; lvl_rd_idx = 0;
    snoop_req = 0; snoop_done = 0; flush_done = 0;
    mon_evt = 0; smi = 0; init = 0; nmi = 0; intr = 0; int_msg = 0;
  endtask

  // one cycle: compare at negedge, then clear pulses
  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk();
      clr();
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk();
    rst_n = 1;
    cyc(3);

    // R2 / R3 / R5: halt, monitor event ignored, snoop round trip, interrupt wake
    cur_req = "R2"; halt_req = 1; mwait_req = 1; mwait_lvl = 3; cyc();
    cur_req = "R3"; mon_evt = 1; cyc(); cyc();
    cur_req = "R2"; mwait_req = 1; mwait_lvl = 1; cyc();
    cur_req = "R5"; snoop_req = 1; cyc(); cyc(2); snoop_done = 1; cyc();
    cur_req = "R3"; intr = 1; cyc(2);

    // R4: monitor-wait wakes on monitor event, snoop returns to it
    cur_req = "R4"; mwait_req = 1; mwait_lvl = 0; cyc();
    cur_req = "R5"; snoop_req = 1; cyc(); snoop_done = 1; cyc();
    cur_req = "R4"; mon_evt = 1; cyc(2);

    // R10 / R5 / R4: level 2 via register read
    cur_req = "R10"; lvl_rd_req = 1; lvl_rd_idx = 2; cyc();
    stpclk = 1; cyc(2); stpclk = 0; cyc();
    cur_req = "R5"; snoop_req = 1; cyc(); snoop_done = 1; stpclk = 1; cyc();
    stpclk = 0; cyc();
    cur_req = "R5"; snoop_req = 1; nmi = 1; cyc(2);
    cur_req = "R4"; mwait_req = 1; mwait_lvl = 1; cyc(); mon_evt = 1; cyc(2);

    // R6 / R8: level 3 through flush
    cur_req = "R6"; lvl_rd_req = 1; lvl_rd_idx = 3; cyc(); cyc(3);
    flush_done = 1; cyc();
    cur_req = "R8"; snoop_req = 1; cyc(); snoop_req = 1; cyc(); halt_req = 1; cyc();
    smi = 1; cyc(2);

    // R9: level 4 by monitor-wait and by register index 5
    cur_req = "R9"; mwait_req = 1; mwait_lvl = 3; cyc(); flush_done = 1; cyc(); cyc(2);
    int_msg = 1; cyc();
    lvl_rd_req = 1; lvl_rd_idx = 5; cyc(); flush_done = 1; cyc(); cyc();
    cur_req = "R8"; mon_evt = 1; cyc();
    cur_req = "R2"; lvl_rd_req = 1; lvl_rd_idx = 4; cyc(); flush_done = 1; cyc(); init = 1; cyc();

    // R2: unused register indices
    cur_req = "R2"; lvl_rd_req = 1; lvl_rd_idx = 6; cyc();
    lvl_rd_req = 1; lvl_rd_idx = 1; cyc(); lvl_rd_req = 1; lvl_rd_idx = 0; cyc(); cyc();

    // R7: flush aborted by wake, also with flush_done in same cycle
    cur_req = "R7"; mwait_req = 1; mwait_lvl = 2; cyc(); cyc(2); init = 1; cyc(); cyc();
    lvl_rd_req = 1; lvl_rd_idx = 4; cyc(); init = 1; flush_done = 1; cyc(); cyc();
    lvl_rd_req = 1; lvl_rd_idx = 3; cyc(); mon_evt = 1; flush_done = 1; cyc(); cyc();

    // R11: asynchronous reset from level 4
    cur_req = "R11"; mwait_req = 1; mwait_lvl = 3; cyc(); flush_done = 1; cyc(); cyc();
    #1 rst_n = 0; #1 chk(); cyc(); rst_n = 1; cyc(2);

    // random mix, all requirements
    cur_req = "R5";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      chk();
      clr();
      halt_req   = ($urandom_range(0, 9) == 0);
      mwait_req  = ($urandom_range(0, 7) == 0);
      mwait_lvl  = 2'($urandom_range(0, 3));
      lvl_rd_req = ($urandom_range(0, 7) == 0);
      lvl_rd_idx = 3'($urandom_range(0, 7));
      snoop_req  = ($urandom_range(0, 3) == 0);
      snoop_done = ($urandom_range(0, 2) == 0);
      flush_done = ($urandom_range(0, 3) == 0);
      mon_evt    = ($urandom_range(0, 15) == 0);
      smi        = ($urandom_range(0, 63) == 0);
      init       = ($urandom_range(0, 63) == 0);
      nmi        = ($urandom_range(0, 63) == 0);
      intr       = ($urandom_range(0, 31) == 0);
      int_msg    = ($urandom_range(0, 63) == 0);
      stpclk     = ($urandom_range(0, 1) == 0);
    end
    cyc();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule